// File: doc/BRIEF.md
# Stepped Regulator Divisor Loader

This block programs the 12-bit divisor of an external core-voltage regulator over a three-wire serial link made of a data line, a shift clock and an active-high load strobe. A request carries a core frequency in kHz and a force flag. The block maps the frequency to one of three divisor codes and then walks the regulator toward that code. No single load changes the divisor by more than a fixed step, so a large voltage swing cannot make the supply droop far enough for the regulator to trip.

Every step is a complete serial word followed by a load strobe. The block remembers the divisor it last loaded and keeps issuing words until that value equals the target. With the force flag set, the first word carries the target itself, which ends the request after one load. Use force when the regulator is already close to the target, for example when the divisor is first initialised at the current operating point.

Top module: `vreg_step_loader`

## Requirements
- R1: The target code is 0xFFF for frequencies below 200000 kHz, 0xDE5 for frequencies from 200000 up to 299999 kHz, and 0x325 for 300000 kHz and above. The last word of every request equals this target.
- R2: Without force, each word is the stored divisor plus 0x100 when the divisor is below target minus 0x100, the stored divisor minus 0x100 when it is above target plus 0x100, and the target otherwise.
- R3: With force set, the request sends exactly one word, equal to the target.
- R4: Words are sent until the stored divisor equals the target, and every request sends at least one word, even when the stored divisor already equals the target.
- R5: A word is 12 bits sent most significant bit first. The receiver takes each bit on the rising edge of the shift clock. The shift clock and the load strobe are both low before a word starts and are never high together.
- R6: Each data bit is driven for at least UNIT_CYC clocks before its shift clock rise and stays unchanged while the shift clock is high. The shift clock is high for exactly UNIT_CYC clocks per bit.
- R7: UNIT_CYC clocks after the last shift clock fall, the load strobe goes high for exactly UNIT_CYC clocks. The stored divisor then takes the word just sent.
- R8: Busy rises in the cycle after a start is accepted and falls only at the end of the final load strobe. Done is a one-cycle pulse at that moment, with busy already low.
- R9: A start that arrives while busy is ignored: it neither changes the words of the running request nor queues a new one.
- R10: Reset puts the stored divisor at 0xFFF, aborts any transfer, and drives busy, done and all three serial lines low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request strobe, accepted only while idle |
| force_i | input | 1 | Load the target in one word, with no stepping |
| freq_khz_i | input | FREQ_W | Requested core frequency in kHz |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | One-cycle pulse when the final load completes |
| sdata_o | output | 1 | Serial data to the regulator |
| sclk_o | output | 1 | Serial shift clock |
| sload_o | output | 1 | Active-high load strobe |

## Verification
A start sampled at one clock edge raises busy at that edge. The first shift clock rise comes UNIT_CYC+1 clocks later, and each later bit arrives 2·UNIT_CYC clocks after the one before. The load strobe rises UNIT_CYC clocks after the last shift clock fall. Done appears in the first cycle after the strobe's UNIT_CYC-clock window. The bench samples on the falling clock edge. It counts the cycles of each low, high and strobe run and compares them with these numbers, instead of waiting a fixed delay. Every captured word is checked against a stepping model that starts from the reset divisor.

// File: rtl/vreg_pkg.sv
package vreg_pkg;

    localparam int DIV_W = 12;

    typedef logic [DIV_W-1:0] div_t;

    typedef enum logic [2:0] {
        SH_IDLE,
        SH_SETUP,
        SH_HIGH,
        SH_TAIL,
        SH_STROBE
    } sh_state_e;

    typedef enum logic [1:0] {
        CT_IDLE,
        CT_ISSUE,
        CT_WAIT
    } ctl_state_e;

    // Bounded move from cur toward tgt; comparisons carry one extra bit so
    // neither tgt-step nor tgt+step can wrap.
    function automatic div_t step_toward(input div_t cur, input div_t tgt,
                                         input div_t step);
        logic [DIV_W:0] c, t, s;
        c = {1'b0, cur};
        t = {1'b0, tgt};
        s = {1'b0, step};
        if (c + s < t)
            return cur + step;
        else if (c > t + s)
            return cur - step;
        else
            return tgt;
    endfunction

endpackage

// File: rtl/vreg_band_decode.sv
module vreg_band_decode
    import vreg_pkg::*;
#(
    parameter int   FREQ_W   = 32,
    parameter int   MID_KHZ  = 200000,
    parameter int   FAST_KHZ = 300000,
    parameter div_t DIV_SLOW = 12'hFFF,
    parameter div_t DIV_MID  = 12'hDE5,
    parameter div_t DIV_FAST = 12'h325
) (
    input  logic [FREQ_W-1:0] freq_khz_i,
    output div_t              target_o
);

    localparam logic [FREQ_W-1:0] MID_LIM  = FREQ_W'(MID_KHZ);
    localparam logic [FREQ_W-1:0] FAST_LIM = FREQ_W'(FAST_KHZ);

    always_comb begin
        if (freq_khz_i < MID_LIM)
            target_o = DIV_SLOW;
        else if (freq_khz_i < FAST_LIM)
            target_o = DIV_MID;
        else
            target_o = DIV_FAST;
    end

endmodule

// File: rtl/vreg_step_calc.sv
module vreg_step_calc
    import vreg_pkg::*;
#(
    parameter div_t STEP = 12'h100
) (
    input  div_t cur_i,
    input  div_t tgt_i,
    input  logic force_i,
    output div_t next_o
);

    always_comb begin
        if (force_i)
            next_o = tgt_i;
        else
            next_o = step_toward(cur_i, tgt_i, STEP);
    end

endmodule

// File: rtl/vreg_unit_timer.sv
module vreg_unit_timer #(
    parameter int UNIT_CYC = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic hold_i,
    output logic tick_o
);

    localparam int CNT_W = (UNIT_CYC > 1) ? $clog2(UNIT_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(UNIT_CYC - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || hold_i)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick_o = !hold_i && (cnt == LAST);

endmodule

// File: rtl/vreg_serial_shifter.sv
module vreg_serial_shifter
    import vreg_pkg::*;
#(
    parameter int UNIT_CYC = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic go_i,
    input  div_t word_i,
    output logic sdata_o,
    output logic sclk_o,
    output logic sload_o,
    output logic fin_o
);

    localparam int IDX_W = $clog2(DIV_W);
    localparam logic [IDX_W-1:0] TOP_BIT = IDX_W'(DIV_W - 1);

    sh_state_e        st;
    div_t             shreg;
    logic [IDX_W-1:0] idx;
    logic             unit_end;

    vreg_unit_timer #(.UNIT_CYC(UNIT_CYC)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .hold_i (st == SH_IDLE),
        .tick_o (unit_end)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= SH_IDLE;
            shreg <= '0;
            idx   <= '0;
        end else begin
            case (st)
                SH_IDLE: begin
                    if (go_i) begin
                        shreg <= word_i;
                        idx   <= TOP_BIT;
                        st    <= SH_SETUP;
                    end
                end
                SH_SETUP: begin
                    if (unit_end)
                        st <= SH_HIGH;
                end
                SH_HIGH: begin
                    if (unit_end) begin
                        if (idx == '0) begin
                            st <= SH_TAIL;
                        end else begin
                            shreg <= {shreg[DIV_W-2:0], 1'b0};
                            idx   <= idx - 1'b1;
                            st    <= SH_SETUP;
                        end
                    end
                end
                SH_TAIL: begin
                    if (unit_end)
                        st <= SH_STROBE;
                end
                SH_STROBE: begin
                    if (unit_end)
                        st <= SH_IDLE;
                end
                default: st <= SH_IDLE;
            endcase
        end
    end

    assign sdata_o = ((st == SH_SETUP) || (st == SH_HIGH)) && shreg[DIV_W-1];
    assign sclk_o  = (st == SH_HIGH);
    assign sload_o = (st == SH_STROBE);
    assign fin_o   = (st == SH_STROBE) && unit_end;

endmodule

// File: rtl/vreg_step_loader.sv
module vreg_step_loader
    import vreg_pkg::*;
#(
    parameter int   FREQ_W    = 32,
    parameter int   UNIT_CYC  = 50,
    parameter int   MID_KHZ   = 200000,
    parameter int   FAST_KHZ  = 300000,
    parameter div_t DIV_SLOW  = 12'hFFF,
    parameter div_t DIV_MID   = 12'hDE5,
    parameter div_t DIV_FAST  = 12'h325,
    parameter div_t STEP      = 12'h100,
    parameter div_t RESET_DIV = 12'hFFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              force_i,
    input  logic [FREQ_W-1:0] freq_khz_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              sdata_o,
    output logic              sclk_o,
    output logic              sload_o
);

    ctl_state_e ctl;
    div_t       cur_div;
    div_t       tgt_q;
    div_t       word_q;
    logic       force_q;
    div_t       band_tgt;
    div_t       next_word;
    logic       fin;

    vreg_band_decode #(
        .FREQ_W   (FREQ_W),
        .MID_KHZ  (MID_KHZ),
        .FAST_KHZ (FAST_KHZ),
        .DIV_SLOW (DIV_SLOW),
        .DIV_MID  (DIV_MID),
        .DIV_FAST (DIV_FAST)
    ) u_band (
        .freq_khz_i (freq_khz_i),
        .target_o   (band_tgt)
    );

    vreg_step_calc #(.STEP(STEP)) u_step (
        .cur_i   (cur_div),
        .tgt_i   (tgt_q),
        .force_i (force_q),
        .next_o  (next_word)
    );

    vreg_serial_shifter #(.UNIT_CYC(UNIT_CYC)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .go_i    (ctl == CT_ISSUE),
        .word_i  (next_word),
        .sdata_o (sdata_o),
        .sclk_o  (sclk_o),
        .sload_o (sload_o),
        .fin_o   (fin)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl     <= CT_IDLE;
            cur_div <= RESET_DIV;
            tgt_q   <= RESET_DIV;
            word_q  <= RESET_DIV;
            force_q <= 1'b0;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (ctl)
                CT_IDLE: begin
                    if (start_i) begin
                        tgt_q   <= band_tgt;
                        force_q <= force_i;
                        ctl     <= CT_ISSUE;
                    end
                end
                CT_ISSUE: begin
                    word_q  <= next_word;
                    force_q <= 1'b0;
                    ctl     <= CT_WAIT;
                end
                CT_WAIT: begin
                    if (fin) begin
                        cur_div <= word_q;
                        if (word_q == tgt_q) begin
                            ctl    <= CT_IDLE;
                            done_o <= 1'b1;
                        end else begin
                            ctl <= CT_ISSUE;
                        end
                    end
                end
                default: ctl <= CT_IDLE;
            endcase
        end
    end

    assign busy_o = (ctl != CT_IDLE);

endmodule

// File: rtl/vreg_step_loader_chk.sv
module vreg_step_loader_chk #(
    parameter int UNIT_CYC = 50
) (
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic busy_o,
    input logic done_o,
    input logic sdata_o,
    input logic sclk_o,
    input logic sload_o
);

    int unsigned hi_run;
    int unsigned ld_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run <= 0;
            ld_run <= 0;
        end else begin
            hi_run <= sclk_o  ? hi_run + 1 : 0;
            ld_run <= sload_o ? ld_run + 1 : 0;
        end
    end

    AST_CLK_LOAD_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(sclk_o && sload_o)); // R5

    AST_IDLE_LINES_LOW: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!sclk_o && !sload_o && !sdata_o)); // R10

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o); // R8

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R8

    AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o); // R8

    AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> done_o); // R8

    AST_DATA_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
        (sclk_o && $past(sclk_o)) |-> $stable(sdata_o)); // R6

    AST_CLK_HIGH_BOUND: assert property (@(posedge clk) disable iff (rst)
        sclk_o |-> (hi_run < UNIT_CYC)); // R6

    AST_LOAD_HIGH_BOUND: assert property (@(posedge clk) disable iff (rst)
        sload_o |-> (ld_run < UNIT_CYC)); // R7

endmodule

bind vreg_step_loader vreg_step_loader_chk #(.UNIT_CYC(UNIT_CYC)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .sdata_o (sdata_o),
    .sclk_o  (sclk_o),
    .sload_o (sload_o)
);

// File: tb/vreg_step_loader_test.sv
module vreg_step_loader_test;

    localparam int U      = 3;
    localparam int NBITS  = 12;
    localparam int MAXW   = 32;

    typedef struct packed {
        logic [31:0] freq;
        logic        frc;
        logic [11:0] tgt;
        logic [7:0]  n;
    } vec_t;

    // freq, force, expected target, expected word count
    localparam vec_t VECS [8] = '{
        '{32'd100000, 1'b0, 12'hFFF, 8'd1},
        '{32'd250000, 1'b0, 12'hDE5, 8'd3},
        '{32'd400000, 1'b0, 12'h325, 8'd11},
        '{32'd199999, 1'b1, 12'hFFF, 8'd1},
        '{32'd200000, 1'b0, 12'hDE5, 8'd3},
        '{32'd299999, 1'b0, 12'hDE5, 8'd1},
        '{32'd300000, 1'b1, 12'h325, 8'd1},
        '{32'd0,      1'b0, 12'hFFF, 8'd13}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        force_i = 1'b0;
    logic [31:0] freq_khz_i = '0;
    logic        busy_o, done_o, sdata_o, sclk_o, sload_o;

    int checks = 0;
    int errors = 0;

    logic [11:0] words [MAXW];
    int          wcount = 0;
    logic [11:0] cur_m = 12'hFFF;

    always #10 clk = ~clk;

    vreg_step_loader #(.UNIT_CYC(U)) uut (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .force_i    (force_i),
        .freq_khz_i (freq_khz_i),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .sdata_o    (sdata_o),
        .sclk_o     (sclk_o),
        .sload_o    (sload_o)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] model_step(input logic [11:0] c,
                                               input logic [11:0] t);
        int ci = int'(c);
        int ti = int'(t);
        if (ci < ti - 256) return 12'(ci + 256);
        if (ci > ti + 256) return 12'(ci - 256);
        return t;
    endfunction

    // Serial line monitor, sampled on the falling clock edge
    logic        p_sclk = 1'b0, p_sload = 1'b0;
    int          low_run = 0, high_run = 0, ld_run = 0, nbits = 0;
    logic [11:0] shw = '0;

    always @(negedge clk) begin
        if (rst) begin
            p_sclk = 1'b0; p_sload = 1'b0;
            low_run = 0; high_run = 0; ld_run = 0; nbits = 0;
        end else begin
            if (sclk_o && !p_sclk) begin
                if (nbits > 0) chk(low_run >= U, "R6 data setup", low_run, U);
                shw = {shw[10:0], sdata_o};
                nbits++;
            end
            if (!sclk_o && p_sclk)
                chk(high_run == U, "R6 clock high width", high_run, U);
            if (sload_o && !p_sload) begin
                chk(nbits == NBITS, "R5 bits per word", nbits, NBITS);
                chk(low_run == U, "R7 strobe delay", low_run, U);
                if (wcount < MAXW) words[wcount] = shw;
                wcount++;
                nbits = 0;
            end
            if (!sload_o && p_sload)
                chk(ld_run == U, "R7 strobe width", ld_run, U);
            if (sclk_o) begin high_run++; low_run = 0; end
            else begin low_run++; high_run = 0; end
            ld_run = sload_o ? ld_run + 1 : 0;
            p_sclk = sclk_o;
            p_sload = sload_o;
        end
    end

    task automatic issue_req(input logic [31:0] f, input logic frc);
        @(negedge clk);
        wcount = 0;
        freq_khz_i = f;
        force_i = frc;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R8 busy after start", busy_o, 1);
    endtask

    task automatic wait_done();
        while (!done_o) @(negedge clk);
        chk(busy_o == 1'b0, "R8 busy low with done", busy_o, 0);
        @(negedge clk);
        chk(done_o == 1'b0, "R8 done single pulse", done_o, 0);
    endtask

    task automatic compare_words(input logic [11:0] tgt, input logic frc,
                                 input int n);
        logic [11:0] e;
        chk(wcount == n, "R4 word count", wcount, n);
        for (int i = 0; i < wcount && i < MAXW; i++) begin
            e = (frc && i == 0) ? tgt : model_step(cur_m, tgt);
            chk(words[i] == e, frc ? "R3 forced word" : "R2 step word",
                words[i], e);
            cur_m = e;
        end
        if (wcount > 0)
            chk(words[wcount-1] == tgt, "R1 final word is band target",
                words[wcount-1], tgt);
        if (frc) chk(wcount == 1, "R3 single forced word", wcount, 1);
    endtask

    task automatic run_req(input logic [31:0] f, input logic frc,
                           input logic [11:0] tgt, input int n);
        issue_req(f, frc);
        wait_done();
        compare_words(tgt, frc, n);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit any_busy;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state at the ports
        chk(busy_o == 0 && done_o == 0, "R10 idle after reset",
            {busy_o, done_o}, 0);
        chk(sclk_o == 0 && sload_o == 0 && sdata_o == 0,
            "R10 serial lines low", {sclk_o, sload_o, sdata_o}, 0);

        // Table walk: bands, boundaries, stepping both ways, force
        for (int i = 0; i < 8; i++)
            run_req(VECS[i].freq, VECS[i].frc, VECS[i].tgt, int'(VECS[i].n));

        // R9: start while busy is ignored
        issue_req(32'd250000, 1'b0);
        repeat (40) @(negedge clk);
        freq_khz_i = 32'd400000;
        force_i = 1'b1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done();
        compare_words(12'hDE5, 1'b0, 3);
        any_busy = 1'b0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (busy_o) any_busy = 1'b1;
        end
        chk(!any_busy, "R9 ignored start not queued", any_busy, 0);

        // R10: reset mid-request returns the stored divisor to 0xFFF
        issue_req(32'd400000, 1'b0);
        repeat (150) @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(busy_o == 0, "R10 busy cleared by reset", busy_o, 0);
        chk(sclk_o == 0 && sload_o == 0, "R10 lines low in reset",
            {sclk_o, sload_o}, 0);
        rst = 1'b0;
        cur_m = 12'hFFF;
        run_req(32'd150000, 1'b0, 12'hFFF, 1);

        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule